// File: doc/BRIEF.md
# Half-Duty LCD Segment Waveform Generator

This block produces the drive waveforms for a multiplexed LCD with two backplanes, half duty and half bias. A display image of up to 90 segments sits on 45 segment pins, two segments per pin, and on two common pins. Every pin is given as a two-bit voltage level code rather than an analog voltage. The external bias network turns the code into VSS, the mid-level or VDD, so no analog circuitry sits inside the block.

A divided oscillator strobe drives a frame counter. One frame lasts `FRAME_DIV` strobes and is split into four equal quarters. In each quarter one common pin is driven to a full rail and the other rests at mid-level. The second half of the frame repeats the first half with the opposite rail, so every segment sees zero net DC over a frame. Several conditions darken the display:

- a blanking control,
- a sleep selection,
- reset.

None of them changes the display image the block is given. A port-select field can take the first segment pins away from the display and use them as plain logic outputs.

Top module: `lcd_halfduty_drv`

## Requirements
- R1: While `rst` is high, every `com_o` and `seg_o` level becomes VSS (2'b00) at the next clock edge, port pins included. After `rst` falls, the frame restarts at quarter 0.
- R2: Each two-bit pin code is 2'b00 for VSS, 2'b01 for mid-level or 2'b10 for VDD. 2'b11 never appears.
- R3: The frame counter advances once per clock edge on which `osc_tick` is high, and holds otherwise. A frame is `FRAME_DIV` ticks in four equal quarters:
  - quarter 0: common 0 (`com_o[1:0]`) at VDD
  - quarter 1: common 1 (`com_o[3:2]`) at VDD
  - quarter 2: common 0 at VSS
  - quarter 3: common 1 at VSS

  The common that is not active is at mid-level.
- R4: Segment pin j (`seg_o[2j+1:2j]`) shows `disp[2j]` while common 0 is active and `disp[2j+1]` while common 1 is active. A bit of 1 drives the rail opposite to the active common; a bit of 0 drives the same rail as the active common.
- R5: All outputs are registered. A change on any input appears on the pins one clock edge later.
- R6: While `seg_on` is 0, both commons and all display segment pins are at VSS. The frame counter keeps running, so the waveform resumes at its current position when `seg_on` returns to 1.
- R7: While `sleep_sel` is non-zero, both commons and all display segment pins are at VSS and the frame counter is held at 0. On wake, the frame starts from quarter 0.
- R8: `port_sel` selects how many of the low segment pins act as ports:
  - 2'b00: none
  - 2'b01: pin 0
  - 2'b10: pins 0 and 1
  - 2'b11: pins 0 to 3

  A port pin outputs VDD when its `port_val` bit is 1 and VSS when it is 0, whatever `seg_on`, `sleep_sel` or the frame position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | Divided oscillator strobe, one frame step per high cycle |
| disp | input | 90 | Display image, two bits per segment pin |
| seg_on | input | 1 | 1 shows the image, 0 blanks the display |
| sleep_sel | input | 2 | Non-zero selects sleep |
| port_sel | input | 2 | Number of segment pins used as ports |
| port_val | input | 4 | Port output values |
| com_o | output | 4 | Common level codes, common 0 in bits 1:0 |
| seg_o | output | 90 | Segment level codes, pin j in bits 2j+1:2j |

## Verification
A frame counter that slips or wraps badly shows within one clock edge as a common at the wrong rail, or at mid-level in the wrong quarter. A wrong sleep hold shows as a frame that does not restart at quarter 0 after wake. A fault in the per-pin polarity or bit selection shows on the first edge of the affected quarter, as a segment code that disagrees with the active common. A port decode error shows one edge after `port_sel` changes, as a pin that follows the display instead of `port_val`.

// File: rtl/lcdh_pkg.sv
package lcdh_pkg;
   localparam logic [1:0] LV_VSS = 2'b00;
   localparam logic [1:0] LV_MID = 2'b01;
   localparam logic [1:0] LV_VDD = 2'b10;
   localparam int         NUM_COM = 2;

   function automatic logic [1:0] lv_flip(input logic [1:0] lv);
      return (lv == LV_VDD) ? LV_VSS : LV_VDD;
   endfunction
endpackage

// File: rtl/lcdh_frame_timer.sv
module lcdh_frame_timer #(
   parameter int FRAME_DIV = 512
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       hold,
   input  logic       tick,
   output logic [1:0] quarter
);
   localparam int CW = $clog2(FRAME_DIV);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst || hold)
         cnt <= '0;
      else if (tick)
         cnt <= cnt + 1'b1;
   end

   assign quarter = cnt[CW-1:CW-2];
endmodule

// File: rtl/lcdh_com_gen.sv
module lcdh_com_gen
   import lcdh_pkg::*;
(
   input  logic [1:0]           quarter,
   input  logic                 dark,
   output logic [2*NUM_COM-1:0] com_lv
);
   logic [1:0] act_lv;
   assign act_lv = quarter[1] ? LV_VSS : LV_VDD;

   for (genvar c = 0; c < NUM_COM; c++) begin : g_com
      assign com_lv[2*c+1:2*c] = dark ? LV_VSS :
                                 (quarter[0] == 1'(c)) ? act_lv : LV_MID;
   end
endmodule

// File: rtl/lcdh_seg_lane.sv
module lcdh_seg_lane
   import lcdh_pkg::*;
(
   input  logic [1:0] bits,
   input  logic [1:0] quarter,
   input  logic       dark,
   output logic [1:0] lv
);
   logic       on_bit;
   logic [1:0] act_lv;

   assign on_bit = quarter[0] ? bits[1] : bits[0];
   assign act_lv = quarter[1] ? LV_VSS : LV_VDD;
   assign lv     = dark ? LV_VSS : (on_bit ? lv_flip(act_lv) : act_lv);
endmodule

// File: rtl/lcd_halfduty_drv.sv
module lcd_halfduty_drv
   import lcdh_pkg::*;
#(
   parameter int SEG_PINS  = 45,
   parameter int PORT_PINS = 4,
   parameter int FRAME_DIV = 512
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    osc_tick,
   input  logic [2*SEG_PINS-1:0]   disp,
   input  logic                    seg_on,
   input  logic [1:0]              sleep_sel,
   input  logic [1:0]              port_sel,
   input  logic [PORT_PINS-1:0]    port_val,
   output logic [2*NUM_COM-1:0]    com_o,
   output logic [2*SEG_PINS-1:0]   seg_o
);
   localparam int DISP_W = 2 * SEG_PINS;

   if (SEG_PINS < 1 || PORT_PINS < 2 || PORT_PINS > SEG_PINS) begin : g_bad_pins
      $error("lcd_halfduty_drv: pin parameters out of range");
   end
   if (FRAME_DIV < 4 || (FRAME_DIV & (FRAME_DIV - 1)) != 0) begin : g_bad_div
      $error("lcd_halfduty_drv: FRAME_DIV must be a power of two >= 4");
   end

   logic                        sleeping;
   logic                        dark;
   logic [1:0]                  quarter;
   logic [2*NUM_COM-1:0]        com_nxt;
   logic [SEG_PINS-1:0][1:0]    seg_nxt;
   logic [2*NUM_COM-1:0]        com_q;
   logic [DISP_W-1:0]           seg_q;

   assign sleeping = (sleep_sel != 2'b00);
   assign dark     = sleeping || !seg_on;

   lcdh_frame_timer #(.FRAME_DIV(FRAME_DIV)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .hold    (sleeping),
      .tick    (osc_tick),
      .quarter (quarter)
   );

   lcdh_com_gen u_com (
      .quarter (quarter),
      .dark    (dark),
      .com_lv  (com_nxt)
   );

   for (genvar i = 0; i < SEG_PINS; i++) begin : g_pin
      logic [1:0] lane_lv;

      lcdh_seg_lane u_lane (
         .bits    (disp[2*i+1:2*i]),
         .quarter (quarter),
         .dark    (dark),
         .lv      (lane_lv)
      );

      if (i < PORT_PINS) begin : g_port
         logic pen;
         assign pen = (port_sel == 2'd3) ||
                      (port_sel == 2'd2 && i < 2) ||
                      (port_sel == 2'd1 && i < 1);
         assign seg_nxt[i] = pen ? (port_val[i] ? LV_VDD : LV_VSS) : lane_lv;
      end else begin : g_disp
         assign seg_nxt[i] = lane_lv;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         com_q <= '0;
         seg_q <= '0;
      end else begin
         com_q <= com_nxt;
         seg_q <= seg_nxt;
      end
   end

   assign com_o = com_q;
   assign seg_o = seg_q;
endmodule

// File: rtl/lcdh_chk.sv
module lcdh_chk #(
   parameter int SEG_PINS  = 45,
   parameter int PORT_PINS = 4
) (
   input logic                   clk,
   input logic                   rst,
   input logic                   seg_on,
   input logic [1:0]             sleep_sel,
   input logic [1:0]             port_sel,
   input logic [PORT_PINS-1:0]   port_val,
   input logic [3:0]             com_o,
   input logic [2*SEG_PINS-1:0]  seg_o
);
   AST_RST_DARK: assert property (@(posedge clk)
      rst |=> (com_o == '0 && seg_o == '0));                              // R1

   AST_COM_LEGAL: assert property (@(posedge clk) disable iff (rst)
      (com_o[1:0] != 2'b11 && com_o[3:2] != 2'b11));                      // R2

   for (genvar j = 0; j < SEG_PINS; j++) begin : g_seg_chk
      AST_SEG_LEGAL: assert property (@(posedge clk) disable iff (rst)
         seg_o[2*j+1:2*j] != 2'b11);                                      // R2
   end

   AST_ONE_MID: assert property (@(posedge clk) disable iff (rst)
      (seg_on && sleep_sel == 2'b00) |=>
      ((com_o[1:0] == 2'b01) != (com_o[3:2] == 2'b01)));                  // R3

   AST_BLANK_DARK: assert property (@(posedge clk) disable iff (rst)
      !seg_on |=> com_o == '0);                                           // R6

   AST_SLEEP_DARK: assert property (@(posedge clk) disable iff (rst)
      (sleep_sel != 2'b00) |=> com_o == '0);                              // R7

   AST_PORT_TOP: assert property (@(posedge clk) disable iff (rst)
      (port_sel == 2'd3) |=>
      seg_o[2*PORT_PINS-1:2*PORT_PINS-2] ==
         ($past(port_val[PORT_PINS-1]) ? 2'b10 : 2'b00));                 // R8
endmodule

bind lcd_halfduty_drv lcdh_chk #(.SEG_PINS(SEG_PINS), .PORT_PINS(PORT_PINS)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .seg_on    (seg_on),
   .sleep_sel (sleep_sel),
   .port_sel  (port_sel),
   .port_val  (port_val),
   .com_o     (com_o),
   .seg_o     (seg_o)
);

// File: tb/lcd_halfduty_drv_bench.sv
module lcd_halfduty_drv_bench;
   localparam int SP = 45;
   localparam int PP = 4;
   localparam int FD = 512;
   localparam int QL = FD / 4;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            osc_tick = 1'b1;
   logic [2*SP-1:0] disp = '0;
   logic            seg_on = 1'b1;
   logic [1:0]      sleep_sel = 2'b00;
   logic [1:0]      port_sel = 2'b00;
   logic [PP-1:0]   port_val = '0;
   logic [3:0]      com_o;
   logic [2*SP-1:0] seg_o;

   int nvec = 0;
   int nbad = 0;
   int bcnt = 0;

   always #5 clk = ~clk;

   lcd_halfduty_drv #(.SEG_PINS(SP), .PORT_PINS(PP), .FRAME_DIV(FD)) u_lcd_halfduty_drv (
      .clk(clk), .rst(rst), .osc_tick(osc_tick), .disp(disp), .seg_on(seg_on),
      .sleep_sel(sleep_sel), .port_sel(port_sel), .port_val(port_val),
      .com_o(com_o), .seg_o(seg_o)
   );

   // One clock edge: expected pins from the inputs and frame position before the edge
   task automatic cyc(input string tag);
      logic [3:0]      ec;
      logic [2*SP-1:0] es;
      int   q, pc;
      bit   dk;
      logic [1:0] al, ol;
      @(posedge clk);
      q  = (bcnt / QL) % 4;
      dk = (sleep_sel != 0) || !seg_on;
      al = (q < 2) ? 2'b10 : 2'b00;
      ol = (q < 2) ? 2'b00 : 2'b10;
      pc = (port_sel == 0) ? 0 : (port_sel == 1) ? 1 : (port_sel == 2) ? 2 : PP;
      ec = '0;
      es = '0;
      if (!rst) begin
         if (!dk) begin
            ec[1:0] = (q % 2 == 0) ? al : 2'b01;
            ec[3:2] = (q % 2 == 1) ? al : 2'b01;
         end
         for (int j = 0; j < SP; j++) begin
            if (j < pc)
               es[2*j +: 2] = port_val[j] ? 2'b10 : 2'b00;
            else if (!dk)
               es[2*j +: 2] = disp[2*j + (q % 2)] ? ol : al;
         end
      end
      if (rst || sleep_sel != 0) bcnt = 0;
      else if (osc_tick) bcnt = (bcnt + 1) % FD;
      @(negedge clk);
      nvec++;
      if (com_o !== ec || seg_o !== es) begin
         nbad++;
         $display("FAIL %s com=%h exp=%h seg=%h exp=%h", tag, com_o, ec, seg_o, es);
      end
   endtask

   task automatic run(input int n, input string tag);
      for (int k = 0; k < n; k++) cyc(tag);
   endtask

   task automatic t_reset;
      port_sel = 2'd3; port_val = 4'hF; disp = {90{1'b1}};
      run(3, "R1 reset dark");
      rst = 1'b0; port_sel = 2'd0; port_val = '0;
      run(QL + 4, "R1 restart q0");
   endtask

   task automatic t_frame;
      disp = {45{2'b10}} ^ 90'h3_0F0F_1234_5678_9ABC_DEF0;
      run(2 * FD, "R3 R4 frame");
   endtask

   task automatic t_patterns;
      disp = '1;               run(FD, "R4 all on");
      disp = '0;               run(FD, "R4 all off R2");
      disp = {45{2'b01}};      run(FD, "R4 com0 only");
   endtask

   task automatic t_ticks;
      for (int k = 0; k < 1500; k++) begin
         osc_tick = (k % 3 == 0);
         cyc("R3 tick gaps");
      end
      osc_tick = 1'b1;
   endtask

   task automatic t_latency;
      for (int k = 0; k < 60; k++) begin
         disp = {3{30'(k * 32'h9E37_79B1)}};
         cyc("R5 latency");
      end
   endtask

   task automatic t_blank;
      seg_on = 1'b0; run(300, "R6 blank");
      seg_on = 1'b1; run(200, "R6 resume");
   endtask

   task automatic t_sleep;
      for (int s = 1; s < 4; s++) begin
         sleep_sel = 2'(s); run(80, "R7 sleep");
      end
      sleep_sel = 2'b00; run(QL + 10, "R7 wake q0");
   endtask

   task automatic t_ports;
      for (int p = 0; p < 4; p++) begin
         port_sel = 2'(p);
         port_val = 4'b1010; run(70, "R8 ports");
         port_val = 4'b0101; seg_on = 1'b0; run(20, "R8 ports blank");
         seg_on = 1'b1; sleep_sel = 2'b10; run(20, "R8 ports sleep");
         sleep_sel = 2'b00; run(QL, "R8 ports run");
      end
      port_sel = 2'd0;
   endtask

   task automatic t_reset_mid;
      run(QL + 30, "R1 pre");
      rst = 1'b1; run(4, "R1 mid reset");
      rst = 1'b0; run(QL + 5, "R1 after");
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_frame();
      t_patterns();
      t_ticks();
      t_latency();
      t_blank();
      t_sleep();
      t_ports();
      t_reset_mid();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog expired at vector %0d", nvec);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule